// File: doc/BRIEF.md
# NAND Protocol Microcode Sequencer

This block is a small microcode engine that steps through command sequences written by firmware and turns them into requests on a NAND interface port. Firmware fills an internal program memory through a write port and then pulses `start` with an entry address. From then on the engine fetches one 32-bit instruction per program counter value and does one of three things with it. It executes register, compare, jump and no-op instructions internally. It hands command, address, data-transfer, delay and bus-stop operations to the NAND interface through a valid/ready handshake. It hands thread-switch and wait-for-event operations to a scheduler port, and waits there until the scheduler answers with `resume`.

The engine has a general-purpose register file of 32-bit registers and a pair of compare flags (equal, greater). A single link register supports one level of subroutine call. The engine can also copy words from an external context memory into a register. Instruction fields are laid out as follows: opcode in [31:28], destination register `rd` in [27:24], a source/condition field in [23:20], a four-bit modifier in [19:16], and a 16-bit immediate in [15:0]. An opcode outside the fourteen defined ones stops the engine and sets an error flag. Only a new `start` clears that flag.

Top module: `nand_ucode_seq`

## Requirements
- R1: After reset `nandValid`, `schedValid` and `errFlag` are 0 and no request appears until `start` is pulsed. A `start` pulse makes the instruction at `startPc` the next one executed.
- R2: Opcodes 0x0 (command/address), 0x1 (data write), 0x2 (data read), 0x5 (delay) and 0xD (stop bus toggle) raise `nandValid` with `nandOp` equal to the opcode. Nothing else raises `nandValid`. `nandOp` and `nandArg` stay stable until `nandReady` is seen, and then the program counter advances.
- R3: For opcodes 0x0, 0x1, 0x2 and 0xD, `nandArg` is register `rd` when bit [16] is 1 and the zero-extended immediate when it is 0. For 0x5 it is always the immediate. When `nandReady` is held high, consecutive data instructions are issued on consecutive cycles.
- R4: Write-register (0x3) with byte offset `b` = bits [17:16] places the immediate at bit 8*b of `rd` and leaves the bytes outside those 16 bits unchanged. For b=3 only immediate bits [7:0] land, in byte 3.
- R5: Copy (0x9) writes register `rs` ([23:20]) into `rd`. Register operation (0xA) writes `rd op x` into `rd`, where x is the zero-extended immediate if bit [16]=1 and `rs` otherwise. The operation is selected by [19:17]: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift left, 6 shift right (amount x[4:0]).
- R6: Compare (0x6) sets the equal flag to (`rd` == imm) and the greater flag to (`rd` > imm, unsigned). Jump (0x4) goes to imm[PC_W-1:0] under condition [23:20]: 0 always, 1 equal, 2 not equal, 3 greater. Otherwise it falls through to the next address.
- R7: Jump condition 4 stores the following address in the link register and jumps. Condition 5 jumps to the link register.
- R8: Delay (0x5) with immediate N, once accepted, holds the program counter for N further cycles. With N=0 it advances right after acceptance.
- R9: Thread switch (0x7) and wait-for-event (0xC) raise `schedValid` with `schedKind` 0 and 1 respectively. The engine holds until `resume` is seen. `schedValid` and `nandValid` are never high together.
- R10: Load context (0xB) drives `ctxRdAddr` from the immediate and writes `ctxRdData` into `rd` in the same cycle.
- R11: Opcodes 0xE and 0xF set `errFlag`, stop execution and keep both valid outputs low until the next `start`, which clears `errFlag`.
- R12: Instructions executed internally (0x3, 0x4, 0x6, 0x8, 0x9, 0xA, 0xB) take exactly one cycle each and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progWe | input | 1 | Program memory write enable |
| progAddr | input | PC_W | Program memory write address |
| progData | input | 32 | Program memory write data |
| start | input | 1 | Begin execution at `startPc` |
| startPc | input | PC_W | Entry address |
| nandValid | output | 1 | NAND interface request valid |
| nandReady | input | 1 | NAND interface accepts request |
| nandOp | output | 4 | Opcode of the NAND request |
| nandArg | output | 32 | Argument of the NAND request |
| schedValid | output | 1 | Scheduler notification valid |
| schedKind | output | 1 | 0 thread switch, 1 wait for event |
| resume | input | 1 | Scheduler releases the engine |
| ctxRdAddr | output | CTX_AW | Context memory read address |
| ctxRdData | input | 32 | Context memory read data |
| errFlag | output | 1 | Undefined opcode was executed |

## Verification
The register path is tried with a table of operand pairs, one for each arithmetic and logic operation. These include a carry across the 16-bit halves, a borrow below zero and a shift by 31, so a wrong operator, a truncated half or a swapped operand shows up as a different word on `nandArg`. Byte-offset writes use overlapping offsets whose result is unique only if untouched bytes survive. Branch tests arrange equal, greater and less comparisons so that every wrongly taken or wrongly skipped jump emits a marker argument or skips an expected request. The timing of each request is counted in cycles after the previous one: a delay of 5 against a delay of 0, and three no-ops in a row. This separates single-cycle internal execution from an off-by-one in the delay counter.

// File: rtl/nus_pkg.sv
package nus_pkg;
  localparam logic [3:0] OP_CMD    = 4'h0;
  localparam logic [3:0] OP_DWR    = 4'h1;
  localparam logic [3:0] OP_DRD    = 4'h2;
  localparam logic [3:0] OP_WRREG  = 4'h3;
  localparam logic [3:0] OP_JUMP   = 4'h4;
  localparam logic [3:0] OP_DELAY  = 4'h5;
  localparam logic [3:0] OP_CMPI   = 4'h6;
  localparam logic [3:0] OP_TSW    = 4'h7;
  localparam logic [3:0] OP_NOP    = 4'h8;
  localparam logic [3:0] OP_COPY   = 4'h9;
  localparam logic [3:0] OP_REGOP  = 4'hA;
  localparam logic [3:0] OP_LDCTX  = 4'hB;
  localparam logic [3:0] OP_WFE    = 4'hC;
  localparam logic [3:0] OP_STOPBUS = 4'hD;

  typedef enum logic [1:0] {WS_IMM, WS_COPY, WS_ALU, WS_CTX} wsrc_e;

  typedef struct packed {
    logic  regWe;
    logic  flagWe;
    wsrc_e wsrc;
  } dpStrobe_t;

  function automatic logic isNandOp(input logic [3:0] op);
    return (op == OP_CMD) || (op == OP_DWR) || (op == OP_DRD) ||
           (op == OP_DELAY) || (op == OP_STOPBUS);
  endfunction

  function automatic logic isSchedOp(input logic [3:0] op);
    return (op == OP_TSW) || (op == OP_WFE);
  endfunction
endpackage

// File: rtl/nus_ctrl.sv
module nus_ctrl
  import nus_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            progWe,
  input  logic [PC_W-1:0] progAddr,
  input  logic [31:0]     progData,
  input  logic            start,
  input  logic [PC_W-1:0] startPc,
  input  logic            eqFlag,
  input  logic            gtFlag,
  input  logic            nandReady,
  input  logic            resume,
  output logic [31:0]     instr,
  output dpStrobe_t       strobe,
  output logic            nandValid,
  output logic            schedValid,
  output logic            schedKind,
  output logic            errFlag
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_DELAY, S_ERR} state_e;

  state_e          state, stateN;
  logic [PC_W-1:0] pc, pcN, link, linkN, target;
  logic [15:0]     cnt, cntN, imm;
  logic [3:0]      opc, cond;
  logic            errN, advance;
  logic [31:0]     progMem [PROG_DEPTH];

  always_ff @(posedge clk) begin
    if (progWe) progMem[progAddr] <= progData;
  end

  assign instr  = progMem[pc];
  assign opc    = instr[31:28];
  assign cond   = instr[23:20];
  assign imm    = instr[15:0];
  assign target = imm[PC_W-1:0];

  assign nandValid  = (state == S_EXEC) && isNandOp(opc);
  assign schedValid = (state == S_EXEC) && isSchedOp(opc);
  assign schedKind  = (opc == OP_WFE);

  always_comb begin
    stateN  = state;
    pcN     = pc;
    linkN   = link;
    cntN    = cnt;
    errN    = errFlag;
    strobe  = '0;
    advance = 1'b0;
    case (state)
      S_EXEC: begin
        if (isNandOp(opc)) begin
          if (nandReady) begin
            if (opc == OP_DELAY && imm != 16'h0) begin
              stateN = S_DELAY;
              cntN   = imm;
            end else begin
              advance = 1'b1;
            end
          end
        end else if (isSchedOp(opc)) begin
          advance = resume;
        end else begin
          case (opc)
            OP_WRREG: begin strobe.regWe = 1'b1; strobe.wsrc = WS_IMM;  advance = 1'b1; end
            OP_COPY:  begin strobe.regWe = 1'b1; strobe.wsrc = WS_COPY; advance = 1'b1; end
            OP_REGOP: begin strobe.regWe = 1'b1; strobe.wsrc = WS_ALU;  advance = 1'b1; end
            OP_LDCTX: begin strobe.regWe = 1'b1; strobe.wsrc = WS_CTX;  advance = 1'b1; end
            OP_CMPI:  begin strobe.flagWe = 1'b1; advance = 1'b1; end
            OP_NOP:   advance = 1'b1;
            OP_JUMP: begin
              case (cond)
                4'd0: pcN = target;
                4'd1: if (eqFlag) pcN = target; else advance = 1'b1;
                4'd2: if (!eqFlag) pcN = target; else advance = 1'b1;
                4'd3: if (gtFlag) pcN = target; else advance = 1'b1;
                4'd4: begin linkN = pc + 1'b1; pcN = target; end
                4'd5: pcN = link;
                default: advance = 1'b1;
              endcase
            end
            default: begin
              stateN = S_ERR;
              errN   = 1'b1;
            end
          endcase
        end
      end
      S_DELAY: begin
        if (cnt == 16'd1) begin
          stateN  = S_EXEC;
          advance = 1'b1;
        end else begin
          cntN = cnt - 16'd1;
        end
      end
      default: ;
    endcase
    if (advance) pcN = pc + 1'b1;
    if (start) begin
      stateN = S_EXEC;
      pcN    = startPc;
      errN   = 1'b0;
      strobe = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pc      <= '0;
      link    <= '0;
      cnt     <= '0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateN;
      pc      <= pcN;
      link    <= linkN;
      cnt     <= cntN;
      errFlag <= errN;
    end
  end
endmodule

// File: rtl/nus_dpath.sv
module nus_dpath
  import nus_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int CTX_DEPTH = 16,
  localparam int RIDX_W = $clog2(NUM_REGS),
  localparam int CTX_AW = $clog2(CTX_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instr,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       ctxRdData,
  output logic [CTX_AW-1:0] ctxRdAddr,
  output logic [31:0]       nandArg,
  output logic              eqFlag,
  output logic              gtFlag
);
  logic [31:0]       regs [NUM_REGS];
  logic [RIDX_W-1:0] rdIdx, rsIdx;
  logic [15:0]       imm;
  logic [31:0]       immExt, rdVal, rsVal, opB, mask, immWr, aluOut, wData;
  logic [4:0]        sh;
  logic [2:0]        aluOp;

  assign rdIdx  = instr[24 +: RIDX_W];
  assign rsIdx  = instr[20 +: RIDX_W];
  assign imm    = instr[15:0];
  assign immExt = {16'h0, imm};
  assign rdVal  = regs[rdIdx];
  assign rsVal  = regs[rsIdx];
  assign aluOp  = instr[19:17];
  assign opB    = instr[16] ? immExt : rsVal;
  assign sh     = {instr[17:16], 3'b000};
  assign mask   = 32'h0000_FFFF << sh;
  assign immWr  = (rdVal & ~mask) | ((immExt << sh) & mask);

  assign ctxRdAddr = imm[CTX_AW-1:0];
  assign nandArg   = (instr[16] && instr[31:28] != OP_DELAY) ? rdVal : immExt;

  always_comb begin
    case (aluOp)
      3'd0:    aluOut = rdVal + opB;
      3'd1:    aluOut = rdVal - opB;
      3'd2:    aluOut = rdVal & opB;
      3'd3:    aluOut = rdVal | opB;
      3'd4:    aluOut = rdVal ^ opB;
      3'd5:    aluOut = rdVal << opB[4:0];
      3'd6:    aluOut = rdVal >> opB[4:0];
      default: aluOut = rdVal;
    endcase
  end

  always_comb begin
    case (strobe.wsrc)
      WS_IMM:  wData = immWr;
      WS_COPY: wData = rsVal;
      WS_ALU:  wData = aluOut;
      default: wData = ctxRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      eqFlag <= 1'b0;
      gtFlag <= 1'b0;
    end else begin
      if (strobe.regWe) regs[rdIdx] <= wData;
      if (strobe.flagWe) begin
        eqFlag <= (rdVal == immExt);
        gtFlag <= (rdVal > immExt);
      end
    end
  end
endmodule

// File: rtl/nand_ucode_seq.sv
module nand_ucode_seq
  import nus_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  parameter int NUM_REGS = 16,
  parameter int CTX_DEPTH = 16,
  localparam int PC_W = $clog2(PROG_DEPTH),
  localparam int CTX_AW = $clog2(CTX_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progWe,
  input  logic [PC_W-1:0]   progAddr,
  input  logic [31:0]       progData,
  input  logic              start,
  input  logic [PC_W-1:0]   startPc,
  output logic              nandValid,
  input  logic              nandReady,
  output logic [3:0]        nandOp,
  output logic [31:0]       nandArg,
  output logic              schedValid,
  output logic              schedKind,
  input  logic              resume,
  output logic [CTX_AW-1:0] ctxRdAddr,
  input  logic [31:0]       ctxRdData,
  output logic              errFlag
);
  logic [31:0] instr;
  dpStrobe_t   strobe;
  logic        eqFlag, gtFlag;

  assign nandOp = instr[31:28];

  nus_ctrl #(.PROG_DEPTH(PROG_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .start(start), .startPc(startPc),
    .eqFlag(eqFlag), .gtFlag(gtFlag), .nandReady(nandReady), .resume(resume),
    .instr(instr), .strobe(strobe), .nandValid(nandValid),
    .schedValid(schedValid), .schedKind(schedKind), .errFlag(errFlag)
  );

  nus_dpath #(.NUM_REGS(NUM_REGS), .CTX_DEPTH(CTX_DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .instr(instr), .strobe(strobe),
    .ctxRdData(ctxRdData), .ctxRdAddr(ctxRdAddr), .nandArg(nandArg),
    .eqFlag(eqFlag), .gtFlag(gtFlag)
  );
endmodule

// File: rtl/nus_chk.sv
module nus_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        nandValid,
  input logic        nandReady,
  input logic [3:0]  nandOp,
  input logic [31:0] nandArg,
  input logic        schedValid,
  input logic        schedKind,
  input logic        resume,
  input logic        errFlag
);
  p_nand_opset_r2: assert property (@(posedge clk) disable iff (!rstN)
    nandValid |-> (nandOp == 4'h0 || nandOp == 4'h1 || nandOp == 4'h2 ||
                   nandOp == 4'h5 || nandOp == 4'hD));

  p_nand_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    nandValid && !nandReady && !start |=> nandValid && $stable(nandOp) && $stable(nandArg));

  p_sched_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    schedValid && !resume && !start |=> schedValid && $stable(schedKind));

  p_excl_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(nandValid && schedValid));

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !nandValid && !schedValid);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !start |=> errFlag);
endmodule

bind nand_ucode_seq nus_chk chk_i (.*);

// File: tb/nand_ucode_seq_tb_top.sv
`timescale 1ns/1ps
module nand_ucode_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progWe = 1'b0;
  logic [4:0]  progAddr = '0;
  logic [31:0] progData = '0;
  logic        start = 1'b0;
  logic [4:0]  startPc = '0;
  logic        nandValid, nandReady = 1'b0;
  logic [3:0]  nandOp;
  logic [31:0] nandArg;
  logic        schedValid, schedKind, resume = 1'b0;
  logic [3:0]  ctxRdAddr;
  logic [31:0] ctxRdData;
  logic        errFlag;
  int          nChk = 0, nFail = 0, cyc = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] ctxVal(input logic [3:0] a);
    return {16'hC7A0, 4'h0, a, 4'h0, a};
  endfunction
  assign ctxRdData = ctxVal(ctxRdAddr);

  nand_ucode_seq dut_i (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .start(start), .startPc(startPc), .nandValid(nandValid), .nandReady(nandReady),
    .nandOp(nandOp), .nandArg(nandArg), .schedValid(schedValid), .schedKind(schedKind),
    .resume(resume), .ctxRdAddr(ctxRdAddr), .ctxRdData(ctxRdData), .errFlag(errFlag)
  );

  // {aluop, a, b, expected}
  localparam logic [98:0] VEC [7] = '{
    {3'd0, 32'h0001_FFFF, 32'h0000_0001, 32'h0002_0000},
    {3'd1, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
    {3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h00F0_1234},
    {3'd3, 32'h1200_0034, 32'h0034_1200, 32'h1234_1234},
    {3'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
    {3'd5, 32'h0000_00FF, 32'h0000_0008, 32'h0000_FF00},
    {3'd6, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001}
  };

  function automatic logic [31:0] ins(input logic [3:0] op, input logic [3:0] rd,
                                      input logic [3:0] f23, input logic [3:0] f19,
                                      input logic [15:0] imm);
    return {op, rd, f23, f19, imm};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired act=%0d exp<=60000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    progWe = 1'b1; progAddr = a[4:0]; progData = d;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic go(input int pc);
    @(negedge clk);
    start = 1'b1; startPc = pc[4:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expectNand(input logic [3:0] op, input logic [31:0] arg, input int expWait, input string tag);
    int w = 0;
    while (!nandValid && w < 80) begin @(negedge clk); w++; end
    if (!nandValid) begin
      chk(1'b0, {tag, " request timeout"}, 32'(w), 32'(expWait));
    end else begin
      chk(nandOp == op, {tag, " op"}, {28'h0, nandOp}, {28'h0, op});
      chk(nandArg == arg, {tag, " arg"}, nandArg, arg);
      if (expWait >= 0) chk(w == expWait, {tag, " cycles"}, 32'(w), 32'(expWait));
      @(negedge clk);
      chk(nandValid && nandOp == op && nandArg == arg && !schedValid, {tag, " hold R2"},
          nandArg, arg);
      nandReady = 1'b1;
      @(negedge clk);
      nandReady = 1'b0;
    end
  endtask

  task automatic expectSched(input logic kind, input string tag);
    int w = 0;
    while (!schedValid && w < 80) begin @(negedge clk); w++; end
    chk(schedValid && schedKind == kind && !nandValid, tag, {31'h0, schedKind}, {31'h0, kind});
    @(negedge clk);
    chk(schedValid && schedKind == kind, {tag, " held"}, {31'h0, schedValid}, 32'h1);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic expectQuiet(input int n, input string tag);
    logic bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (nandValid || schedValid) bad = 1'b1;
    end
    chk(!bad, tag, {31'h0, bad}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing before start
    chk(!nandValid && !schedValid && !errFlag, "R1 reset outputs",
        {29'h0, nandValid, schedValid, errFlag}, 32'h0);
    expectQuiet(6, "R1 idle before start");

    wr(31, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));           // park loop
    // R12 / R1 program at entry 20
    wr(20, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0001));
    wr(21, ins(4'h8, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(22, ins(4'h8, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(23, ins(4'h8, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(24, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0002));
    wr(25, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    go(20);
    expectNand(4'h0, 32'h1, 0, "R1 start entry");
    expectNand(4'h0, 32'h2, 3, "R12 three nops");

    // R5: table of register operations
    for (int i = 0; i < 7; i++) begin
      logic [2:0]  aop = VEC[i][98:96];
      logic [31:0] a = VEC[i][95:64];
      logic [31:0] b = VEC[i][63:32];
      logic [31:0] e = VEC[i][31:0];
      wr(0, ins(4'h3, 4'h1, 4'h0, 4'h0, a[15:0]));
      wr(1, ins(4'h3, 4'h1, 4'h0, 4'h2, a[31:16]));
      wr(2, ins(4'h3, 4'h2, 4'h0, 4'h0, b[15:0]));
      wr(3, ins(4'h3, 4'h2, 4'h0, 4'h2, b[31:16]));
      wr(4, ins(4'hA, 4'h1, 4'h2, {aop, 1'b0}, 16'h0));
      wr(5, ins(4'h0, 4'h1, 4'h0, 4'h1, 16'h0));
      wr(6, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
      go(0);
      expectNand(4'h0, e, 5, $sformatf("R5 alu vector %0d", i));
    end

    // R4 byte offsets, R5 copy/immediate, R3 argument source and back-to-back data
    wr(0, ins(4'h3, 4'h3, 4'h0, 4'h0, 16'h1234));
    wr(1, ins(4'h3, 4'h3, 4'h0, 4'h3, 16'h00CD));
    wr(2, ins(4'h3, 4'h3, 4'h0, 4'h1, 16'hBEEF));
    wr(3, ins(4'h0, 4'h3, 4'h0, 4'h1, 16'h0));
    wr(4, ins(4'h9, 4'h4, 4'h3, 4'h0, 16'h0));
    wr(5, ins(4'hA, 4'h4, 4'h0, 4'h1, 16'h0001));
    wr(6, ins(4'h0, 4'h4, 4'h0, 4'h1, 16'h0));
    wr(7, ins(4'h1, 4'h0, 4'h0, 4'h0, 16'h0200));
    wr(8, ins(4'h2, 4'h0, 4'h0, 4'h0, 16'h0040));
    wr(9, ins(4'hD, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(10, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'hFFFF));
    wr(11, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    go(0);
    expectNand(4'h0, 32'hCDBE_EF34, 3, "R4 byte offsets");
    expectNand(4'h0, 32'hCDBE_EF35, 2, "R5 copy plus immediate");
    expectNand(4'h1, 32'h0000_0200, 0, "R3 data write");
    expectNand(4'h2, 32'h0000_0040, 0, "R3 data read back-to-back");
    expectNand(4'hD, 32'h0, 0, "R2 stop bus toggle");
    expectNand(4'h0, 32'h0000_FFFF, 0, "R3 immediate zero-extended");

    // R6 compare and conditional jumps
    wr(0, ins(4'h3, 4'h5, 4'h0, 4'h0, 16'd10));
    wr(1, ins(4'h6, 4'h5, 4'h0, 4'h0, 16'd10));
    wr(2, ins(4'h4, 4'h0, 4'h1, 4'h0, 16'd4));
    wr(3, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0BAD));
    wr(4, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'd1));
    wr(5, ins(4'h6, 4'h5, 4'h0, 4'h0, 16'd3));
    wr(6, ins(4'h4, 4'h0, 4'h3, 4'h0, 16'd8));
    wr(7, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0BAD));
    wr(8, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'd2));
    wr(9, ins(4'h6, 4'h5, 4'h0, 4'h0, 16'd10));
    wr(10, ins(4'h4, 4'h0, 4'h2, 4'h0, 16'd12));
    wr(11, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'd3));
    wr(12, ins(4'h6, 4'h5, 4'h0, 4'h0, 16'd11));
    wr(13, ins(4'h4, 4'h0, 4'h3, 4'h0, 16'd15));
    wr(14, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'd4));
    wr(15, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    go(0);
    expectNand(4'h0, 32'd1, -1, "R6 jump on equal taken");
    expectNand(4'h0, 32'd2, -1, "R6 jump on greater taken");
    expectNand(4'h0, 32'd3, -1, "R6 jump on not-equal skipped");
    expectNand(4'h0, 32'd4, -1, "R6 jump on greater skipped when less");

    // R7 call and return
    wr(0, ins(4'h4, 4'h0, 4'h4, 4'h0, 16'd4));
    wr(1, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0022));
    wr(2, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    wr(4, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0011));
    wr(5, ins(4'h4, 4'h0, 4'h5, 4'h0, 16'h0));
    go(0);
    expectNand(4'h0, 32'h11, 1, "R7 call enters subroutine");
    expectNand(4'h0, 32'h22, 1, "R7 return to caller");

    // R8 delay
    wr(0, ins(4'h5, 4'h0, 4'h0, 4'h0, 16'd5));
    wr(1, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0055));
    wr(2, ins(4'h5, 4'h0, 4'h0, 4'h0, 16'd0));
    wr(3, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0066));
    wr(4, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    go(0);
    expectNand(4'h5, 32'd5, 0, "R8 delay request");
    expectNand(4'h0, 32'h55, 5, "R8 delay of five");
    expectNand(4'h5, 32'd0, 0, "R8 zero delay request");
    expectNand(4'h0, 32'h66, 0, "R8 zero delay advances");

    // R9 scheduler notifications, R10 context load
    wr(0, ins(4'h7, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(1, ins(4'hC, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(2, ins(4'hB, 4'h6, 4'h0, 4'h0, 16'd3));
    wr(3, ins(4'h0, 4'h6, 4'h0, 4'h1, 16'h0));
    wr(4, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    go(0);
    expectSched(1'b0, "R9 thread switch");
    expectSched(1'b1, "R9 wait for event");
    expectNand(4'h0, ctxVal(4'd3), 1, "R10 context load");

    // R11 undefined opcode
    wr(0, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0001));
    wr(1, ins(4'hE, 4'h0, 4'h0, 4'h0, 16'h0));
    wr(2, ins(4'h0, 4'h0, 4'h0, 4'h0, 16'h0002));
    wr(3, ins(4'h4, 4'h0, 4'h0, 4'h0, 16'd31));
    go(0);
    expectNand(4'h0, 32'h1, 0, "R11 before bad opcode");
    @(negedge clk);
    chk(errFlag, "R11 error flag set", {31'h0, errFlag}, 32'h1);
    expectQuiet(10, "R11 halted after bad opcode");
    chk(errFlag, "R11 error flag sticky", {31'h0, errFlag}, 32'h1);
    go(20);
    chk(!errFlag, "R11 start clears error", {31'h0, errFlag}, 32'h0);
    expectNand(4'h0, 32'h1, 0, "R11 restart runs");

    summary();
    $finish;
  end
endmodule